// File: doc/BRIEF.md
# Sequential Color Channel Arbiter

This block sits between three color request inputs and three light-source driver enables. At any moment it turns on at most one color channel. A request that arrives while another color is lit waits until the lit color's request falls. When several requests are waiting, a fixed red, then green, then blue order picks the winner, whatever order they arrived in. The requests are asynchronous, so each passes through a synchronizer first.

For the granted color, the block reports a 10-bit drive-current code. The code comes from a small register store that holds one code per color in each of three banks, and a bank-select input picks the bank. The block also captures a brightness factor as each color starts and holds it until that color ends. It does no current scaling itself: downstream logic receives the code and the factor and does the arithmetic. When a color ends, a one-cycle pulse reports which color it was.

Top module: `color_seq_arbiter`

## Requirements
- R1: `grant_o` is one-hot or all zero in every cycle, and it is zero after reset. Bit 0 is red, bit 1 is green and bit 2 is blue.
- R2: While a color is granted, a request for another color does not change `grant_o`, however long that request is held.
- R3: When no color is granted, the next grant goes to the lowest-numbered synchronized request: red first, then green, then blue.
- R4: A request raised while the block is idle shows on `grant_o` at the third rising clock edge after it is applied. A released request removes its grant at the third rising edge after the release.
- R5: In the cycle in which a grant clears, `eoc_o` is high for exactly one cycle and `eoc_color_o` holds the ended color (0 red, 1 green, 2 blue). Otherwise `eoc_o` is low.
- R6: A grant never passes directly from one color to another. At least one cycle with no grant separates them, and a waiting request is granted in the cycle right after the clearing cycle.
- R7: `bank_sel_i` picks the bank as follows: 0 gives bank 0, 1 gives bank 1, and both 2 and 3 give bank 2. The choice acts on `code_o` without delay.
- R8: `code_o` is the selected bank's 10-bit code for the granted color, and it is zero when nothing is granted. Bits [7:0] come from the low-half register and bits [9:8] from bits [1:0] of the high-half register.
- R9: `brt_o` takes the value of `brt_i` at the clock edge where a grant begins. It keeps that value for as long as the grant lasts, and it is zero after reset.
- R10: After reset, all three colors hold code 0x181 in bank 0, 0x0E7 in bank 1 and 0x04D in bank 2.
- R11: A write with `wr_en_i` high stores `wr_data_i` to address `2*(3*bank+color)+half`, where half is 0 for the low half and 1 for the high half. Writes to addresses 18 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 3 | Asynchronous color requests: bit 0 red, bit 1 green, bit 2 blue |
| bank_sel_i | input | 2 | Current-code bank select |
| wr_en_i | input | 1 | Code register write strobe |
| wr_addr_i | input | 5 | Code register write address |
| wr_data_i | input | 8 | Code register write data |
| brt_i | input | 8 | Brightness factor offered for the next color |
| grant_o | output | 3 | One-hot driver enable |
| code_o | output | 10 | Current code of the granted color |
| brt_o | output | 8 | Brightness factor captured for the current color |
| eoc_o | output | 1 | One-cycle end-of-color pulse |
| eoc_color_o | output | 2 | Index of the color that just ended |

## Verification
Long random stretches toggle single request bits rarely, so requests overlap in every combination. This separates priority resolution from arrival order, and it separates holding a grant from switching to another color. Directed cases then do four things. They raise all three requests at once, to show the fixed order. They add a red request during green, to show that a waiting request does not interrupt. They change the brightness in the middle of a color, to show the capture timing. They write to out-of-range addresses and to both code halves, to show how the code is built. A cycle-level reference model in the bench checks every output on every cycle, so an off-by-one latency in the synchronizer or the grant register shows up as a mismatch.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   // Index of the lowest set bit of a request vector; valid only when any bit is set.
   function automatic int unsigned lowest_set(input logic [31:0] vec, input int unsigned width);
      int unsigned idx;
      idx = 0;
      for (int i = 31; i >= 0; i--) begin
         if (i < int'(width) && vec[i]) idx = i;
      end
      return idx;
   endfunction

   // Clamp a bank select code onto the implemented banks; codes past the end map to the last bank.
   function automatic int unsigned bank_clamp(input int unsigned sel, input int unsigned banks);
      return (sel >= banks) ? banks - 1 : sel;
   endfunction

endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cseq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cseq_grant_ctrl.sv
module cseq_grant_ctrl #(
   parameter int NUM_COLORS = 3,
   parameter int BRT_W      = 8,
   localparam int CIDX_W    = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_COLORS-1:0] req_s,
   input  logic [BRT_W-1:0]      brt_in,
   output logic [NUM_COLORS-1:0] grant,
   output logic [CIDX_W-1:0]     grant_idx,
   output logic [BRT_W-1:0]      brt_held,
   output logic                  eoc_vld,
   output logic [CIDX_W-1:0]     eoc_idx
);

   logic [NUM_COLORS-1:0] grant_q;
   logic [CIDX_W-1:0]     gidx_q;
   logic [BRT_W-1:0]      brt_q;
   logic                  eoc_q;
   logic [CIDX_W-1:0]     eoc_idx_q;

   logic [NUM_COLORS-1:0] pick;
   logic [CIDX_W-1:0]     pick_idx;
   logic                  held_live;

   // Fixed priority: scanning downwards lets the lowest index win.
   always_comb begin
      pick     = '0;
      pick_idx = '0;
      for (int i = NUM_COLORS - 1; i >= 0; i--) begin
         if (req_s[i]) begin
            pick     = '0;
            pick[i]  = 1'b1;
            pick_idx = CIDX_W'(i);
         end
      end
   end

   assign held_live = |(req_s & grant_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q   <= '0;
         gidx_q    <= '0;
         brt_q     <= '0;
         eoc_q     <= 1'b0;
         eoc_idx_q <= '0;
      end else begin
         eoc_q <= 1'b0;
         if (|grant_q) begin
            if (!held_live) begin
               grant_q   <= '0;
               eoc_q     <= 1'b1;
               eoc_idx_q <= gidx_q;
            end
         end else if (|pick) begin
            grant_q <= pick;
            gidx_q  <= pick_idx;
            brt_q   <= brt_in;
         end
      end
   end

   assign grant     = grant_q;
   assign grant_idx = gidx_q;
   assign brt_held  = brt_q;
   assign eoc_vld   = eoc_q;
   assign eoc_idx   = eoc_idx_q;

endmodule

// File: rtl/cseq_code_bank.sv
module cseq_code_bank
   import cseq_pkg::*;
#(
   parameter int NUM_BANKS  = 3,
   parameter int NUM_COLORS = 3,
   parameter int CODE_W     = 10,
   parameter int LSB_W      = 8,
   parameter logic [NUM_BANKS*CODE_W-1:0] BANK_DEFAULTS = {10'h04D, 10'h0E7, 10'h181},
   localparam int SEL_W     = $clog2(NUM_BANKS),
   localparam int CIDX_W    = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1,
   localparam int ENTRIES   = NUM_BANKS * NUM_COLORS,
   localparam int ADDR_W    = $clog2(2 * ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LSB_W-1:0]  wr_data,
   input  logic [SEL_W-1:0]  bank_sel,
   input  logic [CIDX_W-1:0] color_idx,
   input  logic              color_vld,
   output logic [CODE_W-1:0] code
);

   localparam int MSB_W = CODE_W - LSB_W;

   logic [ENTRIES*CODE_W-1:0] entries_flat;
   logic [SEL_W-1:0]          bank_eff;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      localparam int BANK = e / NUM_COLORS;
      localparam logic [CODE_W-1:0] DEF = BANK_DEFAULTS[BANK*CODE_W +: CODE_W];
      logic [LSB_W-1:0] lo_q;
      logic [MSB_W-1:0] hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= DEF[LSB_W-1:0];
            hi_q <= DEF[CODE_W-1:LSB_W];
         end else if (wr_en) begin
            if (wr_addr == ADDR_W'(2*e))   lo_q <= wr_data;
            if (wr_addr == ADDR_W'(2*e+1)) hi_q <= wr_data[MSB_W-1:0];
         end
      end

      assign entries_flat[e*CODE_W +: CODE_W] = {hi_q, lo_q};
   end

   // Variant: a full power-of-two bank count needs no clamp.
   if (NUM_BANKS == (1 << SEL_W)) begin : g_sel_direct
      assign bank_eff = bank_sel;
   end else begin : g_sel_clamp
      assign bank_eff = SEL_W'(bank_clamp(int'(bank_sel), NUM_BANKS));
   end

   always_comb begin
      int unsigned idx;
      idx  = int'(bank_eff) * NUM_COLORS + int'(color_idx);
      code = '0;
      if (color_vld && idx < ENTRIES) code = entries_flat[idx*CODE_W +: CODE_W];
   end

endmodule

// File: rtl/color_seq_arbiter.sv
module color_seq_arbiter #(
   parameter int NUM_COLORS  = 3,
   parameter int NUM_BANKS   = 3,
   parameter int CODE_W      = 10,
   parameter int LSB_W       = 8,
   parameter int BRT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [NUM_BANKS*CODE_W-1:0] BANK_DEFAULTS = {10'h04D, 10'h0E7, 10'h181}
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [NUM_COLORS-1:0]                   req_i,
   input  logic [$clog2(NUM_BANKS)-1:0]            bank_sel_i,
   input  logic                                    wr_en_i,
   input  logic [$clog2(2*NUM_BANKS*NUM_COLORS)-1:0] wr_addr_i,
   input  logic [LSB_W-1:0]                        wr_data_i,
   input  logic [BRT_W-1:0]                        brt_i,
   output logic [NUM_COLORS-1:0]                   grant_o,
   output logic [CODE_W-1:0]                       code_o,
   output logic [BRT_W-1:0]                        brt_o,
   output logic                                    eoc_o,
   output logic [$clog2(NUM_COLORS)-1:0]           eoc_color_o
);

   localparam int CIDX_W = $clog2(NUM_COLORS);

   if (NUM_COLORS < 2)                        begin : g_bad_colors $error("NUM_COLORS must be at least 2"); end
   if (NUM_BANKS < 2)                         begin : g_bad_banks  $error("NUM_BANKS must be at least 2");  end
   if (CODE_W <= LSB_W || CODE_W > 2*LSB_W)   begin : g_bad_code   $error("CODE_W must lie in (LSB_W, 2*LSB_W]"); end
   if (SYNC_STAGES < 2)                       begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end

   logic [NUM_COLORS-1:0] req_s;
   logic [CIDX_W-1:0]     grant_idx;

   cseq_sync #(
      .WIDTH (NUM_COLORS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (req_i),
      .q    (req_s)
   );

   cseq_grant_ctrl #(
      .NUM_COLORS(NUM_COLORS),
      .BRT_W     (BRT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s),
      .brt_in   (brt_i),
      .grant    (grant_o),
      .grant_idx(grant_idx),
      .brt_held (brt_o),
      .eoc_vld  (eoc_o),
      .eoc_idx  (eoc_color_o)
   );

   cseq_code_bank #(
      .NUM_BANKS    (NUM_BANKS),
      .NUM_COLORS   (NUM_COLORS),
      .CODE_W       (CODE_W),
      .LSB_W        (LSB_W),
      .BANK_DEFAULTS(BANK_DEFAULTS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_addr  (wr_addr_i),
      .wr_data  (wr_data_i),
      .bank_sel (bank_sel_i),
      .color_idx(grant_idx),
      .color_vld(|grant_o),
      .code     (code_o)
   );

endmodule

// File: rtl/color_seq_arbiter_chk.sv
module color_seq_arbiter_chk #(
   parameter int NUM_COLORS = 3,
   parameter int CODE_W     = 10,
   parameter int BRT_W      = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_COLORS-1:0]         grant_o,
   input logic [CODE_W-1:0]             code_o,
   input logic [BRT_W-1:0]              brt_o,
   input logic                          eoc_o,
   input logic [$clog2(NUM_COLORS)-1:0] eoc_color_o
);

   logic [NUM_COLORS-1:0] grant_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant_d <= '0;
      else        grant_d <= grant_o;
   end

   a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   a_r6_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_d != '0) |-> (grant_o == '0 || grant_o == grant_d));

   a_r5_pulse_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_d != '0 && grant_o == '0) |-> eoc_o);

   a_r5_pulse_names_color: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> (grant_o == '0 && grant_d[eoc_color_o]));

   a_r8_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o == '0) |-> (code_o == '0));

   a_r9_brt_held: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_d != '0 && grant_o == grant_d) |-> $stable(brt_o));

endmodule

bind color_seq_arbiter color_seq_arbiter_chk #(
   .NUM_COLORS(NUM_COLORS),
   .CODE_W    (CODE_W),
   .BRT_W     (BRT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .grant_o    (grant_o),
   .code_o     (code_o),
   .brt_o      (brt_o),
   .eoc_o      (eoc_o),
   .eoc_color_o(eoc_color_o)
);

// File: tb/color_seq_arbiter_bench.sv
module color_seq_arbiter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] req = '0;
   logic [1:0] bank_sel = '0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] brt = '0;
   logic [2:0] grant_o;
   logic [9:0] code_o;
   logic [7:0] brt_o;
   logic       eoc_o;
   logic [1:0] eoc_color_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   logic [2:0] m_s1 = '0, m_s2 = '0, m_g = '0;
   logic       m_eoc = 1'b0;
   logic [1:0] m_eoc_c = '0;
   logic [7:0] m_brt = '0;
   logic [9:0] m_code [9];

   always #5 clk = ~clk;

   color_seq_arbiter u_color_seq_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req), .bank_sel_i(bank_sel),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .brt_i(brt),
      .grant_o(grant_o), .code_o(code_o), .brt_o(brt_o),
      .eoc_o(eoc_o), .eoc_color_o(eoc_color_o)
   );

   function automatic logic [2:0] prio(input logic [2:0] r);
      if (r[0]) return 3'b001;
      if (r[1]) return 3'b010;
      if (r[2]) return 3'b100;
      return 3'b000;
   endfunction

   function automatic logic [1:0] idx_of(input logic [2:0] g);
      return g[0] ? 2'd0 : (g[1] ? 2'd1 : 2'd2);
   endfunction

   function automatic logic [9:0] exp_code(input logic [2:0] g, input logic [1:0] sel);
      int b;
      if (g == 3'b000) return 10'h000;
      b = (sel >= 2) ? 2 : int'(sel);
      return m_code[b*3 + int'(idx_of(g))];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      m_eoc = 1'b0;
      if (m_g != 3'b000) begin
         if ((m_s2 & m_g) == 3'b000) begin
            m_eoc = 1'b1; m_eoc_c = idx_of(m_g); m_g = 3'b000;
         end
      end else begin
         m_g = prio(m_s2);
         if (m_g != 3'b000) m_brt = brt;
      end
      if (wr_en && wr_addr < 5'd18) begin
         if (wr_addr[0]) m_code[wr_addr >> 1][9:8] = wr_data[1:0];
         else            m_code[wr_addr >> 1][7:0] = wr_data;
      end
      m_s2 = m_s1;
      m_s1 = req;
      @(negedge clk);
      chk("R1 onehot", 32'($onehot0(grant_o)), 32'd1);
      chk("R2 R3 R4 R6 grant", 32'(grant_o), 32'(m_g));
      chk("R5 eoc", 32'(eoc_o), 32'(m_eoc));
      if (m_eoc) chk("R5 eoc_color", 32'(eoc_color_o), 32'(m_eoc_c));
      chk("R7 R8 code", 32'(code_o), 32'(exp_code(m_g, bank_sel)));
      chk("R9 brt", 32'(brt_o), 32'(m_brt));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int e = 0; e < 9; e++) m_code[e] = (e < 3) ? 10'h181 : ((e < 6) ? 10'h0E7 : 10'h04D);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset grant", 32'(grant_o), 32'd0);
      chk("R5 reset eoc", 32'(eoc_o), 32'd0);
      chk("R8 reset code", 32'(code_o), 32'd0);
      chk("R9 reset brt", 32'(brt_o), 32'd0);

      // all three at once: red wins, three-edge latency, defaults
      req = 3'b111; brt = 8'h5A;
      run(2);
      chk("R4 not yet granted", 32'(grant_o), 32'd0);
      run(1);
      chk("R3 red first", 32'(grant_o), 32'b001);
      chk("R10 bank0 red default", 32'(code_o), 32'h181);
      chk("R9 captured", 32'(brt_o), 32'h5A);
      brt = 8'h33;
      run(4);
      chk("R9 held mid color", 32'(brt_o), 32'h5A);
      req = 3'b110;
      run(2);
      chk("R4 still held", 32'(grant_o), 32'b001);
      run(1);
      chk("R5 clear cycle", 32'({eoc_o, eoc_color_o, grant_o}), 32'({1'b1, 2'd0, 3'b000}));
      run(1);
      chk("R6 next grant green", 32'(grant_o), 32'b010);
      chk("R5 single pulse", 32'(eoc_o), 32'd0);
      chk("R9 new capture", 32'(brt_o), 32'h33);
      bank_sel = 2'd1; run(1);
      chk("R10 bank1 green default", 32'(code_o), 32'h0E7);
      bank_sel = 2'd2; run(1);
      chk("R7 sel 2 to bank2", 32'(code_o), 32'h04D);
      bank_sel = 2'd3; run(1);
      chk("R7 sel 3 to bank2", 32'(code_o), 32'h04D);

      // red arrives while green is lit
      req = 3'b111;
      run(5);
      chk("R2 no preempt", 32'(grant_o), 32'b010);
      req = 3'b101;
      run(3);
      chk("R5 green ended", 32'({eoc_o, eoc_color_o}), 32'({1'b1, 2'd1}));
      run(1);
      chk("R3 red over blue", 32'(grant_o), 32'b001);

      // writes
      bank_sel = 2'd0;
      wr_en = 1'b1; wr_addr = 5'd18; wr_data = 8'hFF; run(1);
      wr_addr = 5'd31; run(1);
      wr_en = 1'b0;
      chk("R11 out of range ignored", 32'(code_o), 32'h181);
      wr_en = 1'b1; wr_addr = 5'd1; wr_data = 8'hFE; run(1);
      chk("R8 high half bits", 32'(code_o), 32'h281);
      wr_addr = 5'd0; wr_data = 8'h12; run(1);
      wr_en = 1'b0;
      chk("R11 low half address", 32'(code_o), 32'h212);

      req = 3'b000;
      run(4);
      chk("R3 idle", 32'(grant_o), 32'd0);
      req = 3'b100;
      run(2);
      chk("R4 blue pending", 32'(grant_o), 32'd0);
      run(1);
      chk("R4 blue granted", 32'(grant_o), 32'b100);
      req = 3'b000;
      run(3);
      chk("R5 blue ended", 32'({eoc_o, eoc_color_o}), 32'({1'b1, 2'd2}));

      // random phase
      for (int c = 0; c < 6000; c++) begin
         if ($urandom % 12 == 0) req = req ^ (3'b001 << ($urandom % 3));
         brt = 8'($urandom);
         wr_en = ($urandom % 10 == 0);
         wr_addr = 5'($urandom);
         wr_data = 8'($urandom);
         if ($urandom % 40 == 0) bank_sel = 2'($urandom);
         step();
      end

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule